// File: doc/BRIEF.md
# Console Bus Address Decoder

This block classifies every access on an 8-bit console bus with a 16-bit address. One cycle after a valid access, it raises exactly one region strobe. The regions are the sound-chip registers, the timer/interrupt-flag pair, high-score RAM, the banked RAM window, ordinary system RAM, a reserved expansion window that swallows writes, and the cartridge. Along with the strobe it gives the 4-bit register index for the sound chip and a RAM address with mirroring already resolved. When a write must land in two places, it also gives a second write address.

A per-page writability table, one bit for each 256-byte page, decides whether an access stays on the console side or goes out to the cartridge. The table comes out of reset with the low quarter of the map writable, and a loader changes one entry at a time. A sticky flag records that high-score RAM has really changed, so that the surrounding system knows it must save that RAM.

The memory arrays, the sound chip, the timer and the cartridge logic sit outside the block. The block only decides which of them is touched and at which address.

Top module: `consoleBusDecoder`

## Requirements
- R1: For each cycle with `accValid` high, exactly one of the seven `sel*` outputs is high during the following cycle only. With `accValid` low, all of them are low in the following cycle. Selects are registered (one clock of latency).
- R2: With `cfgSoundAlt`=0, an address whose bits [15:4] equal 0x400 selects the sound chip for writes. It also does so for reads unless `cfgSoundWriteOnly`=1; such a read is then decoded as any other address. `soundIdx` is address bits [3:0] when `selSound` is high and 0 otherwise.
- R3: With `cfgSoundAlt`=1, the sound chip is selected when (addr & 0xFFC0)==0x0440 or (addr & 0xFFF0)==0x0800, for reads and writes. This takes precedence over every other region, including the reserved window. The 0x4000 window is then not claimed.
- R4: A read with (addr & 0xFFFC)==0x0284 selects the timer and pulses `irqFlagClr` (clear bit 7 of the interrupt flag). `timerIsFlag` equals address bit 0 (1 = flag byte, 0 = count). Writes there are ordinary RAM accesses with no flag clear.
- R5: A write in 0x0460–0x047F on a writable page raises only `selIgnore`. A read there is an ordinary system RAM read.
- R6: On a writable page, an access with (addr & 0x5000)==0x4000 selects banked RAM. A write there with `cfgBankXor`=1 also raises `altWr` with `altAddr` = addr XOR 0x0100.
- R7: On a writable page, an access with (addr & 0xF800)==0x1000 selects high-score RAM.
- R8: `hsDirty` sets on a high-score RAM write only if `accData` differs from `hsOldData` and the address is neither 0x1007 nor 0x17FA or above.
- R9: `hsDirty` clears only on reset or `dirtyClr`. A clear in the same cycle as a qualifying write wins.
- R10: With `cfgMirrorEn`=1, system RAM at 0x0040–0x00FF and 0x0140–0x01FF is the same storage as 0x2040–0x20FF and 0x2140–0x21FF. `ramAddr` is the low copy, and a write also raises `altWr` with `altAddr` = the high copy. With mirroring off, addresses pass unchanged and `altWr` stays 0. `altAddr` is 0 whenever `altWr` is 0.
- R11: After reset, pages 0x00–0x3F are writable and pages 0x40–0xFF are not. A `pageWrEn` cycle sets entry `pageWrIdx` to `pageWrVal` and changes no other page.
- R12: An access to a non-writable page that the sound chip or timer does not claim selects the cartridge as a single-cycle strobe. `ramAddr` always carries the (mirror-corrected) access address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | Access present this cycle |
| accWrite | input | 1 | 1 = write, 0 = read |
| accAddr | input | 16 | Access address |
| accData | input | 8 | Write data |
| hsOldData | input | 8 | Byte currently stored at the high-score address |
| cfgSoundAlt | input | 1 | 0: sound at 0x4000 window, 1: alternate windows |
| cfgSoundWriteOnly | input | 1 | Suppress sound reads in the 0x4000 window |
| cfgMirrorEn | input | 1 | Enable low/high system RAM mirroring |
| cfgBankXor | input | 1 | Duplicate banked writes to addr XOR 0x0100 |
| pageWrEn | input | 1 | Update one writability entry |
| pageWrIdx | input | 8 | Page to update |
| pageWrVal | input | 1 | New writability value |
| dirtyClr | input | 1 | Synchronous clear of the dirty flag |
| selSound | output | 1 | Sound-chip register strobe |
| selTimer | output | 1 | Timer/flag read strobe |
| selHiScore | output | 1 | High-score RAM strobe |
| selBankRam | output | 1 | Banked RAM window strobe (and its shadow) |
| selSysRam | output | 1 | System RAM strobe |
| selIgnore | output | 1 | Reserved-window write, dropped |
| selCart | output | 1 | Cartridge strobe |
| soundIdx | output | 4 | Sound register index |
| timerIsFlag | output | 1 | Timer read targets the flag byte |
| irqFlagClr | output | 1 | Clear interrupt flag bit 7 |
| ramAddr | output | 16 | Mirror-corrected RAM address |
| altWr | output | 1 | Second copy must also be written |
| altAddr | output | 16 | Address of the second copy |
| hsDirty | output | 1 | High-score RAM changed since last clear |

## Verification
The banked RAM window is the hardest state to reach: every page from 0x4000 upward leaves reset non-writable, so any access there falls to the cartridge. The stimulus first shows that fall-through. It then opens single pages through the page-update port, exercises the window with and without the XOR duplicate, and closes a low page again to show that the high-score region then falls to the cartridge too. The dirty flag's exclusions and the same-cycle set-and-clear race are driven by controlling `hsOldData` directly against the write data.

// File: rtl/cbdPkg.sv
package cbdPkg;
  localparam int ADDR_W = 16;

  localparam logic [ADDR_W-1:0] SND_MASK_LO   = 16'hFFC0;
  localparam logic [ADDR_W-1:0] SND_BASE_LO   = 16'h0440;
  localparam logic [ADDR_W-1:0] SND_MASK_HI   = 16'hFFF0;
  localparam logic [ADDR_W-1:0] SND_BASE_HI   = 16'h0800;
  localparam logic [ADDR_W-5:0] SND_MAIN_TOP  = 12'h400;
  localparam logic [ADDR_W-1:0] TMR_MASK      = 16'hFFFC;
  localparam logic [ADDR_W-1:0] TMR_BASE      = 16'h0284;
  localparam logic [ADDR_W-1:0] BANK_MASK     = 16'h5000;
  localparam logic [ADDR_W-1:0] BANK_BASE     = 16'h4000;
  localparam logic [ADDR_W-1:0] BANK_FLIP     = 16'h0100;
  localparam logic [ADDR_W-1:0] HS_MASK       = 16'hF800;
  localparam logic [ADDR_W-1:0] HS_BASE       = 16'h1000;
  localparam logic [ADDR_W-1:0] HS_FUNC_ADDR  = 16'h1007;
  localparam logic [ADDR_W-1:0] HS_TEMP_START = 16'h17FA;
  localparam logic [ADDR_W-1:0] RSV_MASK      = 16'hFFE0;
  localparam logic [ADDR_W-1:0] RSV_BASE      = 16'h0460;
  localparam logic [ADDR_W-1:0] MIR_OFFSET    = 16'h2000;
  localparam logic [ADDR_W-1:0] MIR_LOW_MASK  = 16'h01FF;

  typedef struct packed {
    logic cart;
    logic ignore;
    logic sysRam;
    logic bankRam;
    logic hiScore;
    logic timer;
    logic sound;
  } regionSel_t;

  typedef struct packed {
    regionSel_t sel;
    logic       flagClr;
    logic       timerFlag;
    logic       mirActive;
    logic       mirHigh;
    logic       bankAlt;
    logic       mirAlt;
    logic       dirtySet;
  } ctrlStrobes_t;
endpackage

// File: rtl/cbdPageTable.sv
module cbdPageTable #(
  parameter int PAGE_W   = 8,
  parameter int WR_PAGES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pageWrEn,
  input  logic [PAGE_W-1:0] pageWrIdx,
  input  logic              pageWrVal,
  input  logic [PAGE_W-1:0] lookupIdx,
  output logic              lookupOk
);
  localparam int PAGES = 1 << PAGE_W;

  logic [PAGES-1:0] pageOk;

  for (genvar p = 0; p < PAGES; p++) begin : g_page
    localparam logic RST_VAL = (p < WR_PAGES);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pageOk[p] <= RST_VAL;
      end else if (pageWrEn && (pageWrIdx == PAGE_W'(p))) begin
        pageOk[p] <= pageWrVal;
      end
    end
  end

  assign lookupOk = pageOk[lookupIdx];
endmodule

// File: rtl/cbdControl.sv
module cbdControl
  import cbdPkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PAGE_W   = 8,
  parameter int WR_PAGES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] accData,
  input  logic [DATA_W-1:0] hsOldData,
  input  logic              cfgSoundAlt,
  input  logic              cfgSoundWriteOnly,
  input  logic              cfgMirrorEn,
  input  logic              cfgBankXor,
  input  logic              pageWrEn,
  input  logic [PAGE_W-1:0] pageWrIdx,
  input  logic              pageWrVal,
  output ctrlStrobes_t      strobes
);
  logic pageOk;
  logic soundHit, timerHit, bankHit, hsHit, rsvHit;
  logic mirLow, mirHigh, hsCounts;
  regionSel_t sel;

  cbdPageTable #(.PAGE_W(PAGE_W), .WR_PAGES(WR_PAGES)) u_pages (
    .clk      (clk),
    .rstN     (rstN),
    .pageWrEn (pageWrEn),
    .pageWrIdx(pageWrIdx),
    .pageWrVal(pageWrVal),
    .lookupIdx(accAddr[ADDR_W-1 -: PAGE_W]),
    .lookupOk (pageOk)
  );

  always_comb begin
    if (cfgSoundAlt) begin
      soundHit = ((accAddr & SND_MASK_LO) == SND_BASE_LO) ||
                 ((accAddr & SND_MASK_HI) == SND_BASE_HI);
    end else begin
      soundHit = (accAddr[ADDR_W-1:4] == SND_MAIN_TOP) &&
                 (accWrite || !cfgSoundWriteOnly);
    end
    timerHit = !accWrite && ((accAddr & TMR_MASK) == TMR_BASE);
    bankHit  = (accAddr & BANK_MASK) == BANK_BASE;
    hsHit    = (accAddr & HS_MASK) == HS_BASE;
    rsvHit   = accWrite && ((accAddr & RSV_MASK) == RSV_BASE);
    mirLow   = (accAddr[ADDR_W-1:9] == '0) && (accAddr[7:6] != 2'b00);
    mirHigh  = (accAddr[ADDR_W-1:9] == MIR_OFFSET[ADDR_W-1:9]) && (accAddr[7:6] != 2'b00);
    hsCounts = (accAddr != HS_FUNC_ADDR) && (accAddr < HS_TEMP_START);
  end

  // Priority chain: sound, timer, page writability, then RAM classes.
  always_comb begin
    sel = '0;
    if (accValid) begin
      if (soundHit)      sel.sound   = 1'b1;
      else if (timerHit) sel.timer   = 1'b1;
      else if (!pageOk)  sel.cart    = 1'b1;
      else if (bankHit)  sel.bankRam = 1'b1;
      else if (hsHit)    sel.hiScore = 1'b1;
      else if (rsvHit)   sel.ignore  = 1'b1;
      else               sel.sysRam  = 1'b1;
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.sel       = sel;
    strobes.flagClr   = sel.timer;
    strobes.timerFlag = sel.timer && accAddr[0];
    strobes.mirActive = sel.sysRam && cfgMirrorEn && (mirLow || mirHigh);
    strobes.mirHigh   = mirHigh;
    strobes.bankAlt   = sel.bankRam && accWrite && cfgBankXor;
    strobes.mirAlt    = sel.sysRam && accWrite && cfgMirrorEn && (mirLow || mirHigh);
    strobes.dirtySet  = sel.hiScore && accWrite && hsCounts && (accData != hsOldData);
  end
endmodule

// File: rtl/cbdDatapath.sv
module cbdDatapath
  import cbdPkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              dirtyClr,
  input  ctrlStrobes_t      strobes,
  output regionSel_t        selQ,
  output logic [IDX_W-1:0]  soundIdx,
  output logic              timerIsFlag,
  output logic              irqFlagClr,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              altWr,
  output logic [ADDR_W-1:0] altAddr,
  output logic              hsDirty
);
  logic [ADDR_W-1:0] ramNext, altNext;
  logic [IDX_W-1:0]  idxNext;
  logic              altWrNext;

  always_comb begin
    idxNext   = strobes.sel.sound ? accAddr[IDX_W-1:0] : '0;
    ramNext   = (strobes.mirActive && strobes.mirHigh) ? (accAddr & MIR_LOW_MASK) : accAddr;
    altWrNext = strobes.bankAlt || strobes.mirAlt;
    if (strobes.bankAlt)     altNext = accAddr ^ BANK_FLIP;
    else if (strobes.mirAlt) altNext = (accAddr & MIR_LOW_MASK) | MIR_OFFSET;
    else                     altNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ        <= '0;
      soundIdx    <= '0;
      timerIsFlag <= 1'b0;
      irqFlagClr  <= 1'b0;
      ramAddr     <= '0;
      altWr       <= 1'b0;
      altAddr     <= '0;
    end else begin
      selQ        <= strobes.sel;
      soundIdx    <= idxNext;
      timerIsFlag <= strobes.timerFlag;
      irqFlagClr  <= strobes.flagClr;
      ramAddr     <= ramNext;
      altWr       <= altWrNext;
      altAddr     <= altNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 hsDirty <= 1'b0;
    else if (dirtyClr)         hsDirty <= 1'b0;
    else if (strobes.dirtySet) hsDirty <= 1'b1;
  end
endmodule

// File: rtl/consoleBusDecoder.sv
module consoleBusDecoder
  import cbdPkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 4,
  parameter int PAGE_W   = 8,
  parameter int WR_PAGES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [15:0]       accAddr,
  input  logic [DATA_W-1:0] accData,
  input  logic [DATA_W-1:0] hsOldData,
  input  logic              cfgSoundAlt,
  input  logic              cfgSoundWriteOnly,
  input  logic              cfgMirrorEn,
  input  logic              cfgBankXor,
  input  logic              pageWrEn,
  input  logic [PAGE_W-1:0] pageWrIdx,
  input  logic              pageWrVal,
  input  logic              dirtyClr,
  output logic              selSound,
  output logic              selTimer,
  output logic              selHiScore,
  output logic              selBankRam,
  output logic              selSysRam,
  output logic              selIgnore,
  output logic              selCart,
  output logic [IDX_W-1:0]  soundIdx,
  output logic              timerIsFlag,
  output logic              irqFlagClr,
  output logic [15:0]       ramAddr,
  output logic              altWr,
  output logic [15:0]       altAddr,
  output logic              hsDirty
);
  ctrlStrobes_t strobes;
  regionSel_t   selQ;

  cbdControl #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .WR_PAGES(WR_PAGES)) u_ctrl (
    .clk              (clk),
    .rstN             (rstN),
    .accValid         (accValid),
    .accWrite         (accWrite),
    .accAddr          (accAddr),
    .accData          (accData),
    .hsOldData        (hsOldData),
    .cfgSoundAlt      (cfgSoundAlt),
    .cfgSoundWriteOnly(cfgSoundWriteOnly),
    .cfgMirrorEn      (cfgMirrorEn),
    .cfgBankXor       (cfgBankXor),
    .pageWrEn         (pageWrEn),
    .pageWrIdx        (pageWrIdx),
    .pageWrVal        (pageWrVal),
    .strobes          (strobes)
  );

  cbdDatapath #(.IDX_W(IDX_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .accAddr    (accAddr),
    .dirtyClr   (dirtyClr),
    .strobes    (strobes),
    .selQ       (selQ),
    .soundIdx   (soundIdx),
    .timerIsFlag(timerIsFlag),
    .irqFlagClr (irqFlagClr),
    .ramAddr    (ramAddr),
    .altWr      (altWr),
    .altAddr    (altAddr),
    .hsDirty    (hsDirty)
  );

  assign selSound   = selQ.sound;
  assign selTimer   = selQ.timer;
  assign selHiScore = selQ.hiScore;
  assign selBankRam = selQ.bankRam;
  assign selSysRam  = selQ.sysRam;
  assign selIgnore  = selQ.ignore;
  assign selCart    = selQ.cart;
endmodule

// File: rtl/cbdChecker.sv
module cbdChecker (
  input logic        clk,
  input logic        rstN,
  input logic        accValid,
  input logic        accWrite,
  input logic [15:0] accAddr,
  input logic [7:0]  accData,
  input logic [7:0]  hsOldData,
  input logic        dirtyClr,
  input logic        selSound,
  input logic        selTimer,
  input logic        selHiScore,
  input logic        selBankRam,
  input logic        selSysRam,
  input logic        selIgnore,
  input logic        selCart,
  input logic [3:0]  soundIdx,
  input logic        irqFlagClr,
  input logic        altWr,
  input logic [15:0] altAddr,
  input logic        hsDirty
);
  logic [6:0] selAll;
  assign selAll = {selCart, selIgnore, selSysRam, selBankRam, selHiScore, selTimer, selSound};

  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(selAll));

  assert_sel_needs_access_R1: assert property (@(posedge clk) disable iff (!rstN)
    (selAll != 7'd0) |-> $past(accValid));

  assert_sound_index_R2: assert property (@(posedge clk) disable iff (!rstN)
    selSound |-> (soundIdx == $past(accAddr[3:0])));

  assert_flag_clear_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    irqFlagClr |-> (selTimer && !$past(accWrite)));

  assert_ignore_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    selIgnore |-> ($past(accWrite) && ($past(accAddr[15:5]) == 11'h023)));

  assert_bank_flip_R6: assert property (@(posedge clk) disable iff (!rstN)
    (selBankRam && altWr) |-> (altAddr == ($past(accAddr) ^ 16'h0100)));

  assert_dirty_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsDirty) |-> (selHiScore && ($past(accData) != $past(hsOldData))));

  assert_dirty_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hsDirty) |-> $past(dirtyClr));
endmodule

bind consoleBusDecoder cbdChecker u_cbdChecker (
  .clk       (clk),
  .rstN      (rstN),
  .accValid  (accValid),
  .accWrite  (accWrite),
  .accAddr   (accAddr),
  .accData   (accData),
  .hsOldData (hsOldData),
  .dirtyClr  (dirtyClr),
  .selSound  (selSound),
  .selTimer  (selTimer),
  .selHiScore(selHiScore),
  .selBankRam(selBankRam),
  .selSysRam (selSysRam),
  .selIgnore (selIgnore),
  .selCart   (selCart),
  .soundIdx  (soundIdx),
  .irqFlagClr(irqFlagClr),
  .altWr     (altWr),
  .altAddr   (altAddr),
  .hsDirty   (hsDirty)
);

// File: tb/consoleBusDecoder_bench.sv
`timescale 1ns/1ps
module consoleBusDecoder_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN, accValid, accWrite;
  logic [15:0] accAddr;
  logic [7:0]  accData, hsOldData;
  logic        cfgSoundAlt, cfgSoundWriteOnly, cfgMirrorEn, cfgBankXor;
  logic        pageWrEn, pageWrVal, dirtyClr;
  logic [7:0]  pageWrIdx;
  logic        selSound, selTimer, selHiScore, selBankRam, selSysRam, selIgnore, selCart;
  logic [3:0]  soundIdx;
  logic        timerIsFlag, irqFlagClr, altWr, hsDirty;
  logic [15:0] ramAddr, altAddr;

  consoleBusDecoder u_consoleBusDecoder (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accAddr(accAddr), .accData(accData), .hsOldData(hsOldData),
    .cfgSoundAlt(cfgSoundAlt), .cfgSoundWriteOnly(cfgSoundWriteOnly),
    .cfgMirrorEn(cfgMirrorEn), .cfgBankXor(cfgBankXor),
    .pageWrEn(pageWrEn), .pageWrIdx(pageWrIdx), .pageWrVal(pageWrVal),
    .dirtyClr(dirtyClr),
    .selSound(selSound), .selTimer(selTimer), .selHiScore(selHiScore),
    .selBankRam(selBankRam), .selSysRam(selSysRam), .selIgnore(selIgnore),
    .selCart(selCart), .soundIdx(soundIdx), .timerIsFlag(timerIsFlag),
    .irqFlagClr(irqFlagClr), .ramAddr(ramAddr), .altWr(altWr),
    .altAddr(altAddr), .hsDirty(hsDirty)
  );

  // sel bus encoding: {cart, ignore, sysRam, bankRam, hiScore, timer, sound}
  logic [6:0] selBus;
  assign selBus = {selCart, selIgnore, selSysRam, selBankRam, selHiScore, selTimer, selSound};

  localparam logic [6:0] S_SND = 7'h01, S_TMR = 7'h02, S_HS = 7'h04, S_BANK = 7'h08,
                         S_SYS = 7'h10, S_IGN = 7'h20, S_CART = 7'h40;

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  data;
    logic        alt, wo, mir, bx;
    logic [6:0]  sel;
    logic [3:0]  idx;
    logic [15:0] ram;
    logic        aw;
    logic [15:0] aAddr;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b0,16'h4005,8'h00,1'b0,1'b0,1'b0,1'b0,S_SND ,4'h5,16'h4005,1'b0,16'h0000}, // R2 read in main window
    '{1'b0,16'h4005,8'h00,1'b0,1'b1,1'b0,1'b0,S_CART,4'h0,16'h4005,1'b0,16'h0000}, // R2 write-only read -> R12 cart
    '{1'b1,16'h4003,8'hAA,1'b0,1'b1,1'b0,1'b0,S_SND ,4'h3,16'h4003,1'b0,16'h0000}, // R2 write still hits
    '{1'b1,16'h0447,8'h11,1'b1,1'b0,1'b0,1'b0,S_SND ,4'h7,16'h0447,1'b0,16'h0000}, // R3 low alt window
    '{1'b0,16'h0805,8'h00,1'b1,1'b0,1'b0,1'b0,S_SND ,4'h5,16'h0805,1'b0,16'h0000}, // R3 high alt window
    '{1'b0,16'h4005,8'h00,1'b1,1'b0,1'b0,1'b0,S_CART,4'h0,16'h4005,1'b0,16'h0000}, // R3 main window released
    '{1'b0,16'h0285,8'h00,1'b0,1'b0,1'b0,1'b0,S_TMR ,4'h0,16'h0285,1'b0,16'h0000}, // R4 timer read
    '{1'b1,16'h0285,8'h55,1'b0,1'b0,1'b0,1'b0,S_SYS ,4'h0,16'h0285,1'b0,16'h0000}, // R4 timer write is RAM
    '{1'b1,16'h0465,8'h66,1'b0,1'b0,1'b0,1'b0,S_IGN ,4'h0,16'h0465,1'b0,16'h0000}, // R5 reserved write
    '{1'b1,16'h0465,8'h66,1'b1,1'b0,1'b0,1'b0,S_SND ,4'h5,16'h0465,1'b0,16'h0000}, // R3 precedence over R5
    '{1'b0,16'h0465,8'h00,1'b0,1'b0,1'b0,1'b0,S_SYS ,4'h0,16'h0465,1'b0,16'h0000}, // R5 reserved read
    '{1'b1,16'h0080,8'h12,1'b0,1'b0,1'b1,1'b0,S_SYS ,4'h0,16'h0080,1'b1,16'h2080}, // R10 low copy write
    '{1'b1,16'h2150,8'h34,1'b0,1'b0,1'b1,1'b0,S_SYS ,4'h0,16'h0150,1'b1,16'h2150}, // R10 high copy write
    '{1'b1,16'h2150,8'h34,1'b0,1'b0,1'b0,1'b0,S_SYS ,4'h0,16'h2150,1'b0,16'h0000}, // R10 mirror off
    '{1'b0,16'h2080,8'h00,1'b0,1'b0,1'b1,1'b0,S_SYS ,4'h0,16'h0080,1'b0,16'h0000}, // R10 high copy read
    '{1'b1,16'h0030,8'h00,1'b0,1'b0,1'b1,1'b0,S_SYS ,4'h0,16'h0030,1'b0,16'h0000}, // R10 below mirror range
    '{1'b1,16'h8000,8'h01,1'b0,1'b0,1'b0,1'b0,S_CART,4'h0,16'h8000,1'b0,16'h0000}, // R12 cart write
    '{1'b0,16'h3FFF,8'h00,1'b0,1'b0,1'b0,1'b0,S_SYS ,4'h0,16'h3FFF,1'b0,16'h0000}, // R11 last writable page
    '{1'b0,16'h0288,8'h00,1'b0,1'b0,1'b0,1'b0,S_SYS ,4'h0,16'h0288,1'b0,16'h0000}, // R4 just past timer
    '{1'b1,16'h0801,8'h00,1'b0,1'b0,1'b0,1'b0,S_SYS ,4'h0,16'h0801,1'b0,16'h0000}, // R3 alt off -> RAM
    '{1'b1,16'h1234,8'h00,1'b0,1'b0,1'b0,1'b0,S_HS  ,4'h0,16'h1234,1'b0,16'h0000}  // R7 high-score
  };

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [15:0] a, input logic [7:0] d,
                        input logic [7:0] old, input logic [3:0] cfg);
    @(negedge clk);
    accValid = 1'b1; accWrite = wr; accAddr = a; accData = d; hsOldData = old;
    {cfgSoundAlt, cfgSoundWriteOnly, cfgMirrorEn, cfgBankXor} = cfg;
    @(posedge clk);
    @(negedge clk);
    accValid = 1'b0;
  endtask

  task automatic setPage(input logic [7:0] idx, input logic val);
    @(negedge clk);
    pageWrEn = 1'b1; pageWrIdx = idx; pageWrVal = val;
    @(posedge clk);
    @(negedge clk);
    pageWrEn = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nErrors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; accValid = 1'b0; accWrite = 1'b0; accAddr = '0; accData = '0;
    hsOldData = '0; cfgSoundAlt = 1'b0; cfgSoundWriteOnly = 1'b0; cfgMirrorEn = 1'b0;
    cfgBankXor = 1'b0; pageWrEn = 1'b0; pageWrIdx = '0; pageWrVal = 1'b0; dirtyClr = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 reset selects", 32'(selBus), 32'h0);
    chk("R9 reset dirty", 32'(hsDirty), 32'h0);
    chk("R4 reset flag clear", 32'(irqFlagClr), 32'h0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].data,
             {VECS[i].alt, VECS[i].wo, VECS[i].mir, VECS[i].bx});
      chk($sformatf("R1 vec%0d select", i), 32'(selBus), 32'(VECS[i].sel));
      chk($sformatf("R2 vec%0d soundIdx", i), 32'(soundIdx), 32'(VECS[i].idx));
      chk($sformatf("R10 vec%0d ramAddr", i), 32'(ramAddr), 32'(VECS[i].ram));
      chk($sformatf("R10 vec%0d altWr", i), 32'(altWr), 32'(VECS[i].aw));
      chk($sformatf("R10 vec%0d altAddr", i), 32'(altAddr), 32'(VECS[i].aAddr));
    end

    // R1: idle cycle, strobes drop after one cycle
    @(posedge clk); @(negedge clk);
    chk("R1 idle selects", 32'(selBus), 32'h0);

    // R4: flag clear pulse and flag/count choice
    access(1'b0, 16'h0284, 8'h00, 8'h00, 4'b0000);
    chk("R4 even read clr", 32'(irqFlagClr), 32'h1);
    chk("R4 even read count", 32'(timerIsFlag), 32'h0);
    access(1'b0, 16'h0287, 8'h00, 8'h00, 4'b0000);
    chk("R4 odd read clr", 32'(irqFlagClr), 32'h1);
    chk("R4 odd read flag", 32'(timerIsFlag), 32'h1);
    access(1'b1, 16'h0284, 8'h09, 8'h00, 4'b0000);
    chk("R4 write no clr", 32'(irqFlagClr), 32'h0);
    chk("R4 write is RAM", 32'(selBus), 32'(S_SYS));

    // R11/R12: banked window closed at reset, then opened one page
    access(1'b1, 16'h6120, 8'h01, 8'h00, 4'b0001);
    chk("R12 closed bank page", 32'(selBus), 32'(S_CART));
    setPage(8'h61, 1'b1);
    access(1'b1, 16'h6120, 8'h02, 8'h00, 4'b0001);
    chk("R6 bank select", 32'(selBus), 32'(S_BANK));
    chk("R6 bank xor strobe", 32'(altWr), 32'h1);
    chk("R6 bank xor addr", 32'(altAddr), 32'h6020);
    access(1'b1, 16'h6120, 8'h02, 8'h00, 4'b0000);
    chk("R6 no xor strobe", 32'(altWr), 32'h0);
    access(1'b0, 16'h6120, 8'h00, 8'h00, 4'b0001);
    chk("R6 bank read", 32'(selBus), 32'(S_BANK));
    chk("R6 read no dup", 32'(altWr), 32'h0);
    access(1'b1, 16'h6220, 8'h02, 8'h00, 4'b0000);
    chk("R11 neighbour page untouched", 32'(selBus), 32'(S_CART));
    setPage(8'h70, 1'b1);
    access(1'b1, 16'h7010, 8'h03, 8'h00, 4'b0000);
    chk("R6 0x7000 not banked", 32'(selBus), 32'(S_SYS));
    setPage(8'h12, 1'b0);
    access(1'b1, 16'h1234, 8'h03, 8'h00, 4'b0000);
    chk("R11 page closed -> cart", 32'(selBus), 32'(S_CART));
    chk("R8 cart write no dirty", 32'(hsDirty), 32'h0);

    // R8: dirty qualification
    access(1'b1, 16'h1007, 8'h55, 8'h00, 4'b0000);
    chk("R8 func addr excluded", 32'(hsDirty), 32'h0);
    access(1'b1, 16'h17FA, 8'h55, 8'h00, 4'b0000);
    chk("R7 temp area selects", 32'(selBus), 32'(S_HS));
    chk("R8 temp area excluded", 32'(hsDirty), 32'h0);
    access(1'b1, 16'h1100, 8'h5A, 8'h5A, 4'b0000);
    chk("R8 unchanged data", 32'(hsDirty), 32'h0);
    access(1'b1, 16'h17F9, 8'h01, 8'h02, 4'b0000);
    chk("R8 changed data sets", 32'(hsDirty), 32'h1);
    access(1'b0, 16'h0050, 8'h00, 8'h00, 4'b0000);
    chk("R9 dirty sticky", 32'(hsDirty), 32'h1);

    // R9: clear, and clear wins over a same-cycle set
    @(negedge clk); dirtyClr = 1'b1;
    @(posedge clk); @(negedge clk); dirtyClr = 1'b0;
    chk("R9 clear", 32'(hsDirty), 32'h0);
    @(negedge clk);
    accValid = 1'b1; accWrite = 1'b1; accAddr = 16'h1010; accData = 8'h11;
    hsOldData = 8'h22; dirtyClr = 1'b1;
    @(posedge clk); @(negedge clk);
    accValid = 1'b0; dirtyClr = 1'b0;
    chk("R9 clear beats set", 32'(hsDirty), 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule